// File: doc/BRIEF.md
# Two-Wire Command Frame Slave

This block is the serial front end of a peripheral that takes its orders as short framed commands over a two-wire I2C bus. It samples the clock and data lines with the system clock. It finds start and stop conditions, shifts bytes in and out, and answers the address with an acknowledge. It drives the data line only by pulling it low.

A write frame has a fixed shape. After the address byte comes a command byte, then the high and the low half of a 16-bit target address. When the frame closes with a stop after all three bytes were accepted, the core sees a single-cycle strobe that carries the command and the address. A read frame that follows the address byte directly, with no command byte, returns the core's 16-bit status word. The high byte goes first, the sequence wraps while the master keeps acknowledging, and it ends on the master's not-acknowledge.

The device address is a parameter. The core's command meaning, clock stretching, arbitration and 10-bit addressing lie outside the block.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The first byte after a start is taken MSB first as a 7-bit device address followed by a direction bit (0 = master writes, 1 = master reads). On a match with parameter DEV_ADDR, the block pulls SDA low during the ninth clock of that byte, in both directions.
- R2: If the address does not match, the block never pulls SDA low and never raises the strobe until the next start condition. A matching frame after that next start is served normally.
- R3: In a write frame, the block acknowledges the first three data bytes (command, address high, address low) by pulling SDA low during each ninth clock.
- R4: One system clock after a stop that closes a write frame with exactly three acknowledged data bytes, cmd_valid_o is high for exactly one cycle. cmd_code_o then holds the command byte, and cmd_addr_o holds {high byte, low byte}.
- R5: A write frame that ends with fewer than three data bytes gives no strobe. A fourth data byte is not acknowledged, and that frame gives no strobe either.
- R6: In a read frame the block sends status_i[15:8] and then status_i[7:0], each MSB first. While the master acknowledges, it keeps alternating between the two bytes, starting again with the high byte.
- R7: After the master answers a status byte with a not-acknowledge, the block keeps SDA released until the next start condition.
- R8: A start condition in the middle of a frame discards the partial frame and restarts address reception.
- R9: After reset and after any stop condition, SDA is released and the block is idle with the strobe low.
- R10: SDA is only ever pulled low, never driven high. The block starts pulling it low only while the synchronised SCL is low. Both lines pass through a two-flop synchroniser before edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_low_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| status_i | input | 16 | Status word from the core, high byte sent first |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 8 | Command byte of the last complete frame |
| cmd_addr_o | output | 16 | Address of the last complete frame, high byte in [15:8] |

## Verification
The assertions assume a well-behaved master. SDA moves only while SCL is low, except at intended start and stop conditions. Every SCL phase also lasts longer than the synchroniser and decode latency, so a rising and a falling SCL edge never meet in the same decoded cycle. The bench models the bus as a wired AND of the master's SDA and the block's pull-down. It holds every quarter bit for eight system clocks, changes SDA only at the quarter points of the low phase, and releases SDA whenever the block is expected to answer. Starts and stops are issued only while the block has the line released.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEV_W   = 7;
  localparam int SLOTS   = 3;
  localparam int SLOT_W  = 2;
  localparam int BCNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRX,
    ST_WACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2*BYTE_W-1:0] status_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o
);
  eng_state_t        state_q;
  logic [BCNT_W-1:0] bitcnt_q;
  logic [BYTE_W-1:0] shreg_q, txsh_q;
  logic [SLOT_W-1:0] slot_q;
  logic              rw_q, sts_sel_q, mack_q, drv_q;
  logic              byte_done;
  logic [BYTE_W-1:0] next_sts;

  assign byte_done = scl_fall && (bitcnt_q == BCNT_W'(BYTE_W));
  assign next_sts  = sts_sel_q ? status_i[BYTE_W-1:0] : status_i[2*BYTE_W-1:BYTE_W];

  assign wr_en_o   = !start_ev && !stop_ev && (state_q == ST_WRX) && byte_done
                     && (slot_q < SLOT_W'(SLOTS));
  assign wr_slot_o = slot_q;
  assign wr_data_o = shreg_q;
  // a stop arrives after one sampled clock-high, so at most one bit is counted
  assign commit_o  = stop_ev && (state_q == ST_WRX) && (slot_q == SLOT_W'(SLOTS))
                     && (bitcnt_q <= BCNT_W'(1));
  assign sda_low_o = drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      txsh_q    <= '0;
      slot_q    <= '0;
      rw_q      <= 1'b0;
      sts_sel_q <= 1'b0;
      mack_q    <= 1'b1;
      drv_q     <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      drv_q   <= 1'b0;
    end else if (start_ev) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      slot_q   <= '0;
      drv_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            if (shreg_q[BYTE_W-1:1] == DEV_ADDR) begin
              rw_q    <= shreg_q[0];
              drv_q   <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              txsh_q    <= status_i[2*BYTE_W-1:BYTE_W];
              drv_q     <= ~status_i[2*BYTE_W-1];
              sts_sel_q <= 1'b1;
              bitcnt_q  <= BCNT_W'(1);
              state_q   <= ST_TX;
            end else begin
              drv_q    <= 1'b0;
              bitcnt_q <= '0;
              slot_q   <= '0;
              state_q  <= ST_WRX;
            end
          end
        end
        ST_WRX: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            if (slot_q < SLOT_W'(SLOTS)) begin
              slot_q  <= slot_q + 1'b1;
              drv_q   <= 1'b1;
              state_q <= ST_WACK;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            drv_q    <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ST_WRX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == BCNT_W'(BYTE_W)) begin
              drv_q   <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              drv_q    <= ~txsh_q[BYTE_W-2];
              txsh_q   <= {txsh_q[BYTE_W-2:0], 1'b0};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= sda_s;
          end else if (scl_fall) begin
            if (!mack_q) begin
              txsh_q    <= next_sts;
              drv_q     <= ~next_sts[BYTE_W-1];
              sts_sel_q <= ~sts_sel_q;
              bitcnt_q  <= BCNT_W'(1);
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        default: begin
          drv_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_frame.sv
module i2c_cmd_frame
  import i2c_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                commit,
  output logic                cmd_valid_o,
  output logic [BYTE_W-1:0]   cmd_code_o,
  output logic [2*BYTE_W-1:0] cmd_addr_o
);
  logic [BYTE_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(g)))
        slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
      cmd_addr_o  <= '0;
    end else begin
      cmd_valid_o <= commit;
      if (commit) begin
        cmd_code_o <= slot_q[0];
        cmd_addr_o <= {slot_q[1], slot_q[2]};
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_low_o,
  input  logic [15:0] status_i,
  output logic        cmd_valid_o,
  output logic [7:0]  cmd_code_o,
  output logic [15:0] cmd_addr_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              wr_en, commit;
  logic [SLOT_W-1:0] wr_slot;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .status_i(status_i),
    .sda_low_o(sda_low_o), .wr_en_o(wr_en), .wr_slot_o(wr_slot),
    .wr_data_o(wr_data), .commit_o(commit)
  );

  i2c_cmd_frame frame_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .commit(commit), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .cmd_addr_o(cmd_addr_o)
  );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_lvl,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_low,
  input logic cmd_valid
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R4
  strobe_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(stop_ev));
  // R10
  pull_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_lvl);
  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_low);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_low);
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk chk_i (
  .clk(clk), .rst(rst), .scl_lvl(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_low(sda_low_o), .cmd_valid(cmd_valid_o)
);

// File: tb/i2c_cmd_slave_tb_top.sv
module i2c_cmd_slave_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [15:0] STS = 16'hC35A;
  // {device address, command, address high, address low, expected match}
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    {7'h50, 8'h12, 8'h34, 8'h56, 1'b1},
    {7'h50, 8'hFF, 8'h00, 8'hFF, 1'b1},
    {7'h51, 8'hAA, 8'hBB, 8'hCC, 1'b0},
    {7'h50, 8'h00, 8'hA5, 8'h5A, 1'b1},
    {7'h28, 8'h01, 8'h02, 8'h03, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_low, cmd_valid;
  logic [7:0] cmd_code;
  logic [15:0] cmd_addr;
  wire sda_line = sda_m & ~sda_low;
  int n_cmp = 0, n_bad = 0, drv_cycles = 0, strobes = 0, bad_edges = 0;
  logic prev_low = 1'b0;

  always #10 clk = ~clk;

  i2c_cmd_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_low_o(sda_low),
    .status_i(STS), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_addr_o(cmd_addr)
  );

  always @(posedge clk) begin
    if (sda_low) drv_cycles <= drv_cycles + 1;
    if (cmd_valid) strobes <= strobes + 1;
    if (sda_low && !prev_low && scl_m) bad_edges <= bad_edges + 1;
    prev_low <= sda_low;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic put_bit(logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic get_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; wq(); scl_m = 0; wq(); endtask

  task automatic send_byte(logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset sda", sda_low, 0);
    check("R9 reset strobe", cmd_valid, 0);

    // table of write frames
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      drv_cycles = 0; strobes = 0;
      bus_start();
      send_byte({e[31:25], 1'b0}, ak);
      check(e[0] ? "R1 address ack" : "R2 mismatch no ack", ak, e[0]);
      send_byte(e[24:17], ak); check(e[0] ? "R3 command ack" : "R2 silent", ak, e[0]);
      send_byte(e[16:9], ak);  check(e[0] ? "R3 high ack" : "R2 silent", ak, e[0]);
      send_byte(e[8:1], ak);   check(e[0] ? "R3 low ack" : "R2 silent", ak, e[0]);
      bus_stop();
      check("R4 strobe count", strobes, e[0]);
      if (e[0]) begin
        check("R4 command", cmd_code, e[24:17]);
        check("R4 address", cmd_addr, e[16:1]);
      end else begin
        check("R2 no pull", drv_cycles, 0);
      end
      check("R9 released after stop", sda_low, 0);
    end

    // R6 status readout with wrap, R7 nack ends it
    bus_start();
    send_byte({DEV, 1'b1}, ak); check("R1 read address ack", ak, 1);
    recv_byte(0, rb); check("R6 first status byte", rb, STS[15:8]);
    recv_byte(0, rb); check("R6 second status byte", rb, STS[7:0]);
    recv_byte(0, rb); check("R6 wrap to high byte", rb, STS[15:8]);
    recv_byte(1, rb); check("R6 low byte again", rb, STS[7:0]);
    drv_cycles = 0;
    for (int i = 0; i < 9; i++) put_bit(1);
    check("R7 released after nack", drv_cycles, 0);
    bus_stop();

    // R5 truncated frame
    strobes = 0;
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h21, ak); send_byte(8'h43, ak);
    bus_stop();
    check("R5 truncated no strobe", strobes, 0);

    // R5 overlong frame
    strobes = 0;
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h01, ak); send_byte(8'h02, ak); send_byte(8'h03, ak);
    send_byte(8'h04, ak); check("R5 fourth byte not acked", ak, 0);
    bus_stop();
    check("R5 overlong no strobe", strobes, 0);

    // R8 repeated start mid-frame
    strobes = 0;
    bus_start();
    send_byte({DEV, 1'b0}, ak); send_byte(8'h77, ak);
    bus_start();
    send_byte({DEV, 1'b0}, ak); check("R8 address after restart", ak, 1);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak);
    bus_stop();
    check("R8 one strobe", strobes, 1);
    check("R8 command", cmd_code, 8'h11);
    check("R8 address", cmd_addr, 16'h2233);

    // R2 mismatch then restart to a match
    strobes = 0;
    bus_start();
    send_byte({7'h51, 1'b0}, ak); check("R2 mismatch", ak, 0);
    bus_start();
    send_byte({DEV, 1'b0}, ak); check("R2 match after next start", ak, 1);
    send_byte(8'h9C, ak); send_byte(8'h0F, ak); send_byte(8'hF0, ak);
    bus_stop();
    check("R2 strobe after recovery", strobes, 1);
    check("R2 address after recovery", cmd_addr, 16'h0FF0);

    // R9 stop mid-frame
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    bus_stop();
    check("R9 idle after early stop", sda_low, 0);

    check("R10 pull only in low phase", bad_edges, 0);
    summary();
    $finish;
  end
endmodule